// File: doc/BRIEF.md
# Masked-write clock and reset control register bank

This block holds the control registers of a clock and reset unit: one mode register, a set of clock-select registers, a set of clock-gate registers and a set of soft-reset registers. Every register is 16 bits wide. It sits on a plain register bus with a write strobe, a byte address, 32-bit write data and 32-bit read data.

Every write carries its own per-bit enables. The upper half of the write word says which bits of the lower half may change, so software can set or clear single fields without reading the register first. The soft-reset registers drive a flat vector of active-high reset lines, one per peripheral. The select, gate and mode contents are brought out as flat vectors for the clock logic, which is not part of this block.

Top module: `hiword_reg_bank`

## Requirements
- R1: On a write to a mapped register, bit k (0..15) of that register takes write-data bit k when write-data bit 16+k is 1, and keeps its old value when bit 16+k is 0.
- R2: Read data for a mapped address is the stored 16-bit value in bits 15:0, with bits 31:16 zero. Reads are combinational from the address.
- R3: Reset output line n is bit n%16 of soft-reset register n/16. A stored 1 asserts the line (output high) and a stored 0 releases it.
- R4: The byte addresses are as follows. The mode register is at 0x0A0. Clock-select register i is at 0x100+4i, clock-gate register i is at 0x300+4i, and soft-reset register i is at 0x400+4i.
- R5: After power-on reset every register reads 0, so all gates are open and every reset line is released. The default configuration has 8 select, 15 gate and 4 soft-reset registers.
- R6: A write to an address that maps to no register changes nothing. This covers unaligned addresses, addresses past the last register of a group, and gaps. A read from such an address returns 0.
- R7: While the write strobe is low, no register or output changes, whatever the address and data are.
- R8: A write takes effect at the clock edge where the strobe is sampled high. It is visible on the reads and outputs from then on.
- R9: The mode, select and gate output vectors carry the stored registers in order, with register i in bits 16i+15:16i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data: enables in 31:16, values in 15:0 |
| rdata_o | output | 32 | Read data for addr_i |
| mode_o | output | 16 | Mode register contents |
| sel_o | output | 128 | Clock-select registers, packed |
| gate_o | output | 240 | Clock-gate registers, packed |
| rst_o | output | 64 | Soft-reset lines, active high |

## Verification
The masked write is tried in four ways: with all enables set, with only some enables set, with no enables set, and with enables on bits whose data is opposite to their stored value. Together these separate a correct merge from a plain overwrite, from an inverted mask, and from a design that ignores the enables. Single reset lines in the middle of a register are set and then released, which shows whether the index-to-bit mapping is wrong or off by one. Writes to gap addresses, unaligned addresses and addresses one past the end of a group, plus strobe-low cycles, show whether the address decode is loose. A long mixed sequence is compared against a behavioural model on every clock, and a reset in the middle of the run checks that everything returns to its reset value.

// File: rtl/hwreg_pkg.sv
package hwreg_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned HW = 16;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] MODE_OFS  = 12'h0A0;
  localparam logic [AW-1:0] SEL_BASE  = 12'h100;
  localparam logic [AW-1:0] GATE_BASE = 12'h300;
  localparam logic [AW-1:0] RST_BASE  = 12'h400;
endpackage

// File: rtl/hw_mask_reg.sv
module hw_mask_reg
  import hwreg_pkg::*;
#(
  parameter logic [HW-1:0] RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [HW-1:0] q_o
);
  logic [HW-1:0] en;
  logic [HW-1:0] val;
  assign en  = wdata_i[DW-1:HW];
  assign val = wdata_i[HW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (wr_i) q_o <= (q_o & ~en) | (val & en);
  end

  assert_masked_keep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(q_o)) & ~$past(en)) == '0);
  assert_enabled_take_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ((q_o ^ $past(val)) & $past(en)) == '0);
  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/hwreg_decode.sv
module hwreg_decode
  import hwreg_pkg::*;
#(
  parameter int unsigned NUM_SEL  = 8,
  parameter int unsigned NUM_GATE = 15,
  parameter int unsigned NUM_RST  = 4,
  localparam int unsigned NREG = 1 + NUM_SEL + NUM_GATE + NUM_RST
) (
  input  logic [AW-1:0]   addr_i,
  output logic [NREG-1:0] hit_o
);
  assign hit_o[0] = (addr_i == MODE_OFS);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    localparam logic [AW-1:0] A = SEL_BASE + AW'(4 * i);
    assign hit_o[1 + i] = (addr_i == A);
  end
  for (genvar i = 0; i < NUM_GATE; i++) begin : g_gate
    localparam logic [AW-1:0] A = GATE_BASE + AW'(4 * i);
    assign hit_o[1 + NUM_SEL + i] = (addr_i == A);
  end
  for (genvar i = 0; i < NUM_RST; i++) begin : g_rst
    localparam logic [AW-1:0] A = RST_BASE + AW'(4 * i);
    assign hit_o[1 + NUM_SEL + NUM_GATE + i] = (addr_i == A);
  end
endmodule

// File: rtl/hwreg_rdmux.sv
module hwreg_rdmux
  import hwreg_pkg::*;
#(
  parameter int unsigned NREG = 28
) (
  input  logic [NREG-1:0]         hit_i,
  input  logic [NREG-1:0][HW-1:0] regs_i,
  output logic [DW-1:0]           rdata_o
);
  logic [HW-1:0] acc;
  always_comb begin
    acc = '0;
    for (int k = 0; k < NREG; k++) acc |= regs_i[k] & {HW{hit_i[k]}};
  end
  assign rdata_o = {{(DW-HW){1'b0}}, acc};
endmodule

// File: rtl/hiword_reg_bank.sv
module hiword_reg_bank
  import hwreg_pkg::*;
#(
  parameter int unsigned NUM_SEL  = 8,
  parameter int unsigned NUM_GATE = 15,
  parameter int unsigned NUM_RST  = 4,
  localparam int unsigned NREG = 1 + NUM_SEL + NUM_GATE + NUM_RST
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [11:0]            addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic [15:0]            mode_o,
  output logic [NUM_SEL*16-1:0]  sel_o,
  output logic [NUM_GATE*16-1:0] gate_o,
  output logic [NUM_RST*16-1:0]  rst_o
);
  localparam int unsigned SEL_IDX  = 1;
  localparam int unsigned GATE_IDX = SEL_IDX + NUM_SEL;
  localparam int unsigned RST_IDX  = GATE_IDX + NUM_GATE;

  logic [NREG-1:0]         hit;
  logic [NREG-1:0][HW-1:0] regs;

  hwreg_decode #(.NUM_SEL(NUM_SEL), .NUM_GATE(NUM_GATE), .NUM_RST(NUM_RST)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    hw_mask_reg #(.RST_VAL('0)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (we_i & hit[k]),
      .wdata_i (wdata_i),
      .q_o     (regs[k])
    );
  end

  hwreg_rdmux #(.NREG(NREG)) u_rd (
    .hit_i   (hit),
    .regs_i  (regs),
    .rdata_o (rdata_o)
  );

  assign mode_o = regs[0];
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel_o
    assign sel_o[16*i +: 16] = regs[SEL_IDX + i];
  end
  for (genvar i = 0; i < NUM_GATE; i++) begin : g_gate_o
    assign gate_o[16*i +: 16] = regs[GATE_IDX + i];
  end
  for (genvar i = 0; i < NUM_RST; i++) begin : g_rst_o
    assign rst_o[16*i +: 16] = regs[RST_IDX + i];
  end

  assert_single_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
  assert_rst_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rst_o));
  assert_unmapped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> (rdata_o == '0));
endmodule

// File: tb/tb_hiword_reg_bank.sv
module tb_hiword_reg_bank;
  localparam int NS = 8, NG = 15, NR = 4;

  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        we_i = 0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] mode_o;
  logic [NS*16-1:0] sel_o;
  logic [NG*16-1:0] gate_o;
  logic [NR*16-1:0] rst_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mdl [int];

  always #10 clk_i = ~clk_i;

  hiword_reg_bank dut (.*);

  function automatic bit mapped(int a);
    if (a == 'h0A0) return 1;
    if (a >= 'h100 && a < 'h100 + 4*NS && a % 4 == 0) return 1;
    if (a >= 'h300 && a < 'h300 + 4*NG && a % 4 == 0) return 1;
    if (a >= 'h400 && a < 'h400 + 4*NR && a % 4 == 0) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] mrd(int a);
    if (mapped(a) && mdl.exists(a)) return mdl[a];
    return 16'h0;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1; addr_i = 12'(a); wdata_i = d;
    @(posedge clk_i);
    #1;
    we_i = 0;
    if (mapped(a)) mdl[a] = (mrd(a) & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic rd(string tag, int a);
    @(negedge clk_i);
    addr_i = 12'(a);
    #1;
    check(tag, 256'(rdata_o), 256'({16'h0, mrd(a)}));
  endtask

  // R9 R3: every clock, outputs against model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic [NR*16-1:0] er;
      logic [NS*16-1:0] es;
      logic [NG*16-1:0] eg;
      for (int n = 0; n < NR*16; n++) er[n] = mrd('h400 + 4*(n/16))[n%16];
      for (int i = 0; i < NS; i++) es[16*i +: 16] = mrd('h100 + 4*i);
      for (int i = 0; i < NG; i++) eg[16*i +: 16] = mrd('h300 + 4*i);
      check("R3 rst_o", 256'(rst_o), 256'(er));
      check("R9 sel_o", 256'(sel_o), 256'(es));
      check("R9 gate_o", 256'(gate_o), 256'(eg));
      check("R9 mode_o", 256'(mode_o), 256'(mrd('h0A0)));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(100000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R5: reset values
    rd("R5 mode", 'h0A0);
    for (int i = 0; i < NS; i++) rd("R5 sel", 'h100 + 4*i);
    for (int i = 0; i < NG; i++) rd("R5 gate", 'h300 + 4*i);
    for (int i = 0; i < NR; i++) rd("R5 rst", 'h400 + 4*i);

    // R1 R2 R4 R8: full, partial, empty masks
    wr('h104, 32'hFFFF_1234); rd("R1 full mask", 'h104);
    wr('h104, 32'h00F0_ABCD); rd("R1 partial mask", 'h104);
    check("R1 partial value", 256'(rdata_o), 256'(32'h0000_12C4));
    wr('h104, 32'h0000_FFFF); rd("R1 empty mask", 'h104);
    check("R1 empty value", 256'(rdata_o), 256'(32'h0000_12C4));
    wr('h104, 32'h8001_0000); rd("R1 clear bits", 'h104);
    check("R1 clear value", 256'(rdata_o), 256'(32'h0000_12C4));
    wr('h104, 32'h0003_0001); rd("R1 bits 0..1", 'h104);
    check("R2 upper zero", 256'(rdata_o[31:16]), 256'(0));
    wr('h0A0, 32'h0003_0002); rd("R4 mode addr", 'h0A0);
    wr('h300 + 4*(NG-1), 32'hFFFF_0F0F); rd("R4 last gate", 'h300 + 4*(NG-1));
    wr('h100 + 4*(NS-1), 32'hFFFF_A5A5); rd("R4 last sel", 'h100 + 4*(NS-1));

    // R3: line 37 -> register 2 bit 5
    wr('h408, 32'h0020_0020);
    @(negedge clk_i); check("R3 line 37 set", 256'(rst_o[37]), 256'(1));
    check("R3 neighbours", 256'(rst_o[38] | rst_o[36] | rst_o[21]), 256'(0));
    wr('h408, 32'h0020_0000);
    @(negedge clk_i); check("R3 line 37 released", 256'(rst_o[37]), 256'(0));
    wr('h400 + 4*(NR-1), 32'h8000_8000);
    @(negedge clk_i); check("R3 top line", 256'(rst_o[NR*16-1]), 256'(1));

    // R6: unmapped writes and reads
    wr('h300 + 4*NG, 32'hFFFF_FFFF); rd("R6 past gate", 'h300 + 4*NG);
    wr('h100 + 4*NS, 32'hFFFF_FFFF); rd("R6 past sel", 'h100 + 4*NS);
    wr('h400 + 4*NR, 32'hFFFF_FFFF); rd("R6 past rst", 'h400 + 4*NR);
    wr('h102, 32'hFFFF_FFFF); rd("R6 unaligned", 'h102);
    wr('h0A4, 32'hFFFF_FFFF); rd("R6 gap", 'h0A4);
    wr('h000, 32'hFFFF_FFFF); rd("R6 zero", 'h000);
    rd("R6 sel0 intact", 'h100);

    // R7: strobe low
    @(negedge clk_i); we_i = 0; addr_i = 12'h408; wdata_i = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk_i);
    rd("R7 strobe low", 'h408);

    // mixed sequence
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 30);
      int a;
      if (k == 0) a = 'h0A0;
      else if (k <= NS) a = 'h100 + 4*(k-1);
      else if (k <= NS+NG) a = 'h300 + 4*(k-1-NS);
      else if (k <= NS+NG+NR) a = 'h400 + 4*(k-1-NS-NG);
      else a = $urandom_range(0, 'h4FF);
      wr(a, $urandom);
      if (i % 4 == 0) rd("R1 mixed", a);
    end

    // R5: reset mid-run
    @(negedge clk_i); rst_ni = 0; mdl.delete();
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    rd("R5 after reset sel", 'h104);
    rd("R5 after reset rst", 'h408);
    rd("R5 after reset gate", 'h300 + 4*(NG-1));
    rd("R5 after reset mode", 'h0A0);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule